// File: doc/BRIEF.md
# Ping-Pong Matrix Block Interleaver

This block reorders a stream of 3-bit coded symbols so that symbols adjacent on the way in are far apart on the way out. A burst of channel errors then lands on symbols that the decoder sees as scattered. Each frame holds 50 symbols arranged as a 10-row by 5-column matrix. Symbols enter row by row and leave column by column.

Two matrix stores alternate. While one frame drains to the output, the next frame fills the other store. A continuous input stream therefore gives a continuous output stream after one frame of latency. The input has a valid flag that may gap. A frame is only released once all of its 50 entries have been accepted.

Top module: `ilv_matrix_pingpong`

## Requirements
- R1: While reset is asserted, and after it is released, both stores are empty, out_valid is 0 and out_sym is 0. A partly filled frame that is cut off by reset never appears at the output.
- R2: Within a frame, the k-th accepted symbol (k = 0..49) goes to matrix position row = k / 5, col = k mod 5. The j-th output symbol (j = 0..49) is taken from row = j mod 10, col = j / 10. In other words, output j equals input (j mod 10)*5 + j/10.
- R3: out_valid first rises in the cycle right after the cycle in which the 50th symbol of a frame is accepted. It then stays high for exactly 50 cycles per frame.
- R4: A cycle with in_valid low accepts nothing, and the fill position holds. A frame is released only after 50 symbols have been accepted, however they are spread in time.
- R5: With in_valid held high, successive frames leave back to back. After the first frame's latency, out_valid stays high for 50 cycles per frame with no gap between frames.
- R6: A new frame is accepted into the idle store while the previous frame is still being read. Both stores are never full at the same time.
- R7: out_sym is 0 in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input symbol qualifier |
| in_sym | input | 3 | Coded symbol to interleave |
| out_valid | output | 1 | Output symbol qualifier |
| out_sym | output | 3 | Interleaved symbol, 0 when idle |

## Verification
The two functions that share a cycle are the fill of one store and the drain of the other. The hardest case is the cycle in which the last entry of the draining frame is read and the last entry of the filling frame is written. In that cycle one store turns empty and the other turns full, and the read side must hand over with no idle cycle. A stream of three frames with in_valid held high provokes this case twice. A behavioural queue model is compared with the outputs on every cycle, and the length of the valid run is checked against 150.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   typedef enum logic {
      SEL_PING = 1'b0,
      SEL_PONG = 1'b1
   } bank_sel_e;

   localparam int NUM_BANKS = 2;

   function automatic bank_sel_e other_bank(input bank_sel_e s);
      return (s == SEL_PING) ? SEL_PONG : SEL_PING;
   endfunction

endpackage

// File: rtl/ilv_scan.sv
module ilv_scan
   import ilv_pkg::*;
#(
   parameter int ROWS      = 10,
   parameter int COLS      = 5,
   parameter bit ROW_MAJOR = 1'b1,
   localparam int DEPTH    = ROWS * COLS,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] addr,
   output logic          last,
   output bank_sel_e     sel
);

   localparam int INNER_N = ROW_MAJOR ? COLS : ROWS;
   localparam int OUTER_N = ROW_MAJOR ? ROWS : COLS;
   localparam int IW      = $clog2(INNER_N);
   localparam int OW      = $clog2(OUTER_N);

   if (ROWS < 2 || COLS < 2) begin : g_bad_shape
      $error("ilv_scan: matrix needs at least 2 rows and 2 columns");
   end

   logic [IW-1:0] inner_q;
   logic [OW-1:0] outer_q;
   bank_sel_e     sel_q;
   logic          inner_wrap;
   logic          outer_wrap;

   assign inner_wrap = (inner_q == IW'(INNER_N - 1));
   assign outer_wrap = (outer_q == OW'(OUTER_N - 1));
   assign last       = inner_wrap && outer_wrap;
   assign sel        = sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inner_q <= '0;
         outer_q <= '0;
         sel_q   <= SEL_PING;
      end else if (adv) begin
         if (inner_wrap) begin
            inner_q <= '0;
            if (outer_wrap) begin
               outer_q <= '0;
               sel_q   <= other_bank(sel_q);
            end else begin
               outer_q <= outer_q + 1'b1;
            end
         end else begin
            inner_q <= inner_q + 1'b1;
         end
      end
   end

   if (ROW_MAJOR) begin : g_row_major
      assign addr = AW'(outer_q) * AW'(COLS) + AW'(inner_q);
   end else begin : g_col_major
      assign addr = AW'(inner_q) * AW'(COLS) + AW'(outer_q);
   end

endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
   parameter int DEPTH = 50,
   parameter int SYM_W = 3,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [SYM_W-1:0] wr_data,
   input  logic             wr_last,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   input  logic             rd_last,
   output logic [SYM_W-1:0] rd_data,
   output logic             full
);

   logic [SYM_W-1:0] cell_q [DEPTH];
   logic             full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            cell_q[i] <= '0;
         end
      end else if (wr_en) begin
         cell_q[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (wr_en && wr_last) begin
         full_q <= 1'b1;
      end else if (rd_en && rd_last) begin
         full_q <= 1'b0;
      end
   end

   assign rd_data = cell_q[rd_addr];
   assign full    = full_q;

endmodule

// File: rtl/ilv_matrix_pingpong.sv
module ilv_matrix_pingpong
   import ilv_pkg::*;
#(
   parameter int ROWS  = 10,
   parameter int COLS  = 5,
   parameter int SYM_W = 3,
   localparam int DEPTH = ROWS * COLS,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SYM_W-1:0] in_sym,
   output logic             out_valid,
   output logic [SYM_W-1:0] out_sym
);

   if (SYM_W < 1) begin : g_bad_width
      $error("ilv_matrix_pingpong: symbol width must be positive");
   end

   logic [NUM_BANKS-1:0] buf_full;
   logic [SYM_W-1:0]     bank_rd [NUM_BANKS];
   logic [AW-1:0]        wr_addr;
   logic [AW-1:0]        rd_addr;
   logic                 wr_last;
   logic                 rd_last;
   bank_sel_e            wr_sel;
   bank_sel_e            rd_sel;
   logic                 wr_fire;
   logic                 rd_fire;

   assign wr_fire = in_valid && !buf_full[wr_sel];
   assign rd_fire = buf_full[rd_sel];

   ilv_scan #(
      .ROWS      (ROWS),
      .COLS      (COLS),
      .ROW_MAJOR (1'b1)
   ) u_wr_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (wr_fire),
      .addr  (wr_addr),
      .last  (wr_last),
      .sel   (wr_sel)
   );

   ilv_scan #(
      .ROWS      (ROWS),
      .COLS      (COLS),
      .ROW_MAJOR (1'b0)
   ) u_rd_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (rd_fire),
      .addr  (rd_addr),
      .last  (rd_last),
      .sel   (rd_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam bank_sel_e ME = (b == 0) ? SEL_PING : SEL_PONG;

      ilv_bank #(
         .DEPTH (DEPTH),
         .SYM_W (SYM_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_fire && (wr_sel == ME)),
         .wr_addr (wr_addr),
         .wr_data (in_sym),
         .wr_last (wr_last),
         .rd_en   (rd_fire && (rd_sel == ME)),
         .rd_addr (rd_addr),
         .rd_last (rd_last),
         .rd_data (bank_rd[b]),
         .full    (buf_full[b])
      );
   end

   assign out_valid = rd_fire;
   assign out_sym   = rd_fire ? bank_rd[rd_sel] : '0;

endmodule

module ilv_matrix_chk #(
   parameter int DEPTH = 50
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       out_valid,
   input logic [1:0] full,
   input logic       rd_sel
);

   logic [31:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (out_valid) begin
         run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   // R1: nothing is held or shown while reset is applied
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && full == 2'b00));

   // R3: output starts only right after an accepted symbol completes a frame
   assert_start_after_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid));

   // R3: every valid run is a whole number of frames
   assert_whole_frames_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> ((run_q % DEPTH) == 0));

   // R5: the read side moves to the other store only after reading
   assert_sel_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel != $past(rd_sel)) |-> $past(out_valid));

   // R6: fill keeps pace with drain, so both stores are never full together
   assert_never_both_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(&full));

endmodule

bind ilv_matrix_pingpong ilv_matrix_chk #(
   .DEPTH (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .full      (buf_full),
   .rd_sel    (rd_sel)
);

// File: tb/ilv_matrix_pingpong_tb_top.sv
module ilv_matrix_pingpong_tb_top;

   localparam int ROWS  = 10;
   localparam int COLS  = 5;
   localparam int DEPTH = ROWS * COLS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] in_sym = '0;
   logic       out_valid;
   logic [2:0] out_sym;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    mon_on   = 1'b0;
   string phase    = "R1 reset";
   int    collect[$];
   int    outq[$];
   int    run_len  = 0;
   int    last_run = 0;
   int    sent     = 0;

   always #5 clk = ~clk;

   ilv_matrix_pingpong dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sym    (in_sym),
      .out_valid (out_valid),
      .out_sym   (out_sym)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] pat(input int i);
      return 3'((i * 3 + i / 7 + 1) % 8);
   endfunction

   // behavioural reference: accepted symbols gather into frames, frames queue for output
   always @(posedge clk) begin
      if (!rst_n) begin
         collect.delete();
         outq.delete();
      end else begin
         if (outq.size() > 0) void'(outq.pop_front());
         if (in_valid) begin
            collect.push_back(int'(in_sym));
            if (collect.size() == DEPTH) begin
               for (int j = 0; j < DEPTH; j++) begin
                  outq.push_back(collect[(j % ROWS) * COLS + j / ROWS]);
               end
               collect.delete();
            end
         end
      end
   end

   always @(negedge clk) begin
      bit exp_v;
      int exp_s;
      exp_v = rst_n && (outq.size() > 0);
      exp_s = exp_v ? outq[0] : 0;
      if (mon_on) begin
         check(out_valid == exp_v, {phase, " R3 out_valid"}, int'(out_valid), int'(exp_v));
         check(int'(out_sym) == exp_s, {phase, " R2/R7 out_sym"}, int'(out_sym), exp_s);
      end
      if (out_valid) begin
         run_len++;
      end else if (run_len > 0) begin
         last_run = run_len;
         run_len  = 0;
      end
   end

   task automatic put(input bit v, input logic [2:0] s);
      in_valid = v;
      in_sym   = s;
      @(posedge clk);
      #1;
   endtask

   task automatic send(input int n);
      for (int i = 0; i < n; i++) begin
         put(1'b1, pat(sent));
         sent++;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) put(1'b0, 3'd0);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired, R1..R7 run incomplete");
      summary();
      $finish;
   end

   initial begin
      mon_on = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      check(out_sym == 3'd0, "R1 out_sym in reset", int'(out_sym), 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      idle(4);

      // R5 and R6: three frames back to back
      phase = "R5/R6 continuous";
      send(75);
      @(negedge clk);
      check(out_valid == 1'b1, "R6 read overlaps fill", int'(out_valid), 1);
      send(75);
      idle(120);
      check(last_run == 3 * DEPTH, "R5 unbroken valid run", last_run, 3 * DEPTH);

      // R4: gaps in the input stall filling
      phase = "R4 gapped";
      for (int i = 0; i < DEPTH - 1; i++) begin
         send(1);
         idle(i % 3);
      end
      idle(20);
      check(out_valid == 1'b0, "R4 frame held at 49 entries", int'(out_valid), 0);
      send(1);
      @(negedge clk);
      check(out_valid == 1'b1, "R3 release after 50th entry", int'(out_valid), 1);
      for (int i = 0; i < DEPTH; i++) begin
         send(1);
         idle(i % 2);
      end
      idle(80);
      check(last_run == DEPTH, "R3 run of one frame", last_run, DEPTH);

      // R1: a reset drops a partial frame
      phase = "R1 mid-frame reset";
      send(30);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      send(20);
      idle(10);
      check(out_valid == 1'b0, "R1 partial frame discarded", int'(out_valid), 0);
      check(out_sym == 3'd0, "R7 idle output zero", int'(out_sym), 0);
      send(30);
      idle(60);
      check(last_run == DEPTH, "R3 frame after reset", last_run, DEPTH);

      summary();
      $finish;
   end

endmodule